// File: doc/BRIEF.md
# Memory Operand Alignment Fault Checker

This block sits next to a load/store unit and inspects every memory access request for a misaligned operand. Each request carries an address, a data-type code, an operand-size attribute, an access class, an implicit-privilege flag, two alignment enable bits (one from a control register, one from the running task's flags) and the current privilege level. The block returns a registered verdict: pass, alignment-check fault or general-protection fault. The verdict comes with the address and type code of the access that produced it.

Misalignment is found by masking the low four address bits with the required alignment minus one. Alignment-check faults are raised only for data and stack accesses made in user mode (privilege 3) while both enable bits are set, and never for implicitly privileged accesses. A misaligned 128-bit operand always raises a general-protection fault. For the 512-byte extended-state save area, a parameter selects which fault is reported.

Requests use a valid/ready handshake into a single output register. That register holds the verdict until the consumer accepts it. A one-cycle fault pulse accompanies each fault verdict as it is loaded.

Top module: `align_chk`

## Requirements
- R1: After reset, rsp_valid_o and fault_pulse_o are 0.
- R2: An alignment-check verdict (code 1) is produced only when ctl_align_mask_i=1, task_align_flag_i=1 and cpl_i=3. Otherwise every alignment-checked type returns pass (code 0).
- R3: Accesses of class code fetch (2) or system structure (3) always return pass. Only data (0) and stack (1) are checked.
- R4: An access with req_implicit_priv_i=1 never produces an alignment-check verdict.
- R5: Types word (1), segment selector (5) and 32-bit far pointer (6) fault when address bit 0 is set.
- R6: Types doubleword (2), 48-bit far pointer (7), 32-bit pointer (8), single float (9) and descriptor register image (12) fault when address bits [1:0] are not 0.
- R7: Types quadword (3), double float (10) and extended float (11) fault when address bits [2:0] are not 0.
- R8: A data or stack access of type 128-bit (4) with address bits [3:0] not 0 returns general-protection (code 2), whatever the enables, the privilege level or the implicit flag. An aligned one returns pass.
- R9: Types environment save area (13), FPU save area (14) and bit string (15) need 4-byte alignment when req_opsize32_i=1 and 2-byte alignment when it is 0.
- R10: Type extended-state area (16) needs 16-byte alignment. When enabled and misaligned, it reports code 2 if parameter XSAVE_GP=1 and code 1 otherwise.
- R11: Byte (0) and unknown type codes (17 to 31) always return pass.
- R12: req_ready_o = !rsp_valid_o | rsp_ready_i. A held verdict, address and type stay stable until accepted.
- R13: fault_pulse_o is high for exactly the cycle in which a fault verdict is first presented. It is never high with a pass verdict.
- R14: rsp_addr_o and rsp_type_o equal the address and type of the accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request can be accepted |
| req_addr_i | input | ADDR_W | Access address |
| req_type_i | input | 5 | Data-type code |
| req_opsize32_i | input | 1 | Operand size is 32-bit (else 16-bit) |
| req_class_i | input | 2 | Access class: 0 data, 1 stack, 2 code, 3 system |
| req_implicit_priv_i | input | 1 | Access runs implicitly at privilege 0 |
| ctl_align_mask_i | input | 1 | Control-register alignment mask bit |
| task_align_flag_i | input | 1 | Per-task alignment flag |
| cpl_i | input | 2 | Current privilege level |
| rsp_valid_o | output | 1 | Verdict valid |
| rsp_ready_i | input | 1 | Consumer accepts verdict |
| rsp_verdict_o | output | 2 | 0 pass, 1 alignment-check, 2 general-protection |
| rsp_addr_o | output | ADDR_W | Address of the judged access |
| rsp_type_o | output | 5 | Type code of the judged access |
| fault_pulse_o | output | 1 | One-cycle pulse with a new fault verdict |

## Verification
The assertions check on every cycle the properties that hold for any request: stability of a held verdict under backpressure, the fault pulse agreeing with a fault verdict, pass for code and system classes and for bytes, no alignment fault without all three enable conditions, the 128-bit general-protection rule, and address capture. Only the bench's reference model can show the per-type alignment table, the operand-size dependence, the extended-state area choice and the implicit-privilege exemption. It does this by sweeping every type code across low address offsets under each enable, class and privilege combination, and then running randomized traffic with random backpressure.

// File: rtl/align_chk_pkg.sv
package align_chk_pkg;
  typedef enum logic [1:0] {
    VERD_PASS = 2'd0,
    VERD_AC   = 2'd1,
    VERD_GP   = 2'd2
  } verdict_e;

  localparam logic [1:0] CLS_DATA  = 2'd0;
  localparam logic [1:0] CLS_STACK = 2'd1;
  localparam logic [1:0] CLS_CODE  = 2'd2;
  localparam logic [1:0] CLS_SYS   = 2'd3;

  localparam int TYPE_W = 5;
  localparam logic [TYPE_W-1:0] T_BYTE   = 5'd0;
  localparam logic [TYPE_W-1:0] T_WORD   = 5'd1;
  localparam logic [TYPE_W-1:0] T_DWORD  = 5'd2;
  localparam logic [TYPE_W-1:0] T_QWORD  = 5'd3;
  localparam logic [TYPE_W-1:0] T_DQWORD = 5'd4;
  localparam logic [TYPE_W-1:0] T_SEL    = 5'd5;
  localparam logic [TYPE_W-1:0] T_FAR32  = 5'd6;
  localparam logic [TYPE_W-1:0] T_FAR48  = 5'd7;
  localparam logic [TYPE_W-1:0] T_PTR32  = 5'd8;
  localparam logic [TYPE_W-1:0] T_FLT32  = 5'd9;
  localparam logic [TYPE_W-1:0] T_FLT64  = 5'd10;
  localparam logic [TYPE_W-1:0] T_FLT80  = 5'd11;
  localparam logic [TYPE_W-1:0] T_DTRIMG = 5'd12;
  localparam logic [TYPE_W-1:0] T_ENVSAV = 5'd13;
  localparam logic [TYPE_W-1:0] T_FPUSAV = 5'd14;
  localparam logic [TYPE_W-1:0] T_BITSTR = 5'd15;
  localparam logic [TYPE_W-1:0] T_XSTATE = 5'd16;

  localparam int LOW_W = 4;
endpackage

// File: rtl/align_chk_decode.sv
module align_chk_decode
  import align_chk_pkg::*;
(
  input  logic [TYPE_W-1:0] type_i,
  input  logic              opsize32_i,
  output logic [LOW_W-1:0]  mask_o,
  output logic              is_dq_o,
  output logic              is_xs_o
);
  // mask = required alignment - 1
  always_comb begin
    unique case (type_i)
      T_WORD, T_SEL, T_FAR32:                      mask_o = 4'h1;
      T_DWORD, T_FAR48, T_PTR32, T_FLT32, T_DTRIMG: mask_o = 4'h3;
      T_QWORD, T_FLT64, T_FLT80:                   mask_o = 4'h7;
      T_ENVSAV, T_FPUSAV, T_BITSTR:                mask_o = opsize32_i ? 4'h3 : 4'h1;
      T_DQWORD, T_XSTATE:                          mask_o = 4'hF;
      default:                                     mask_o = 4'h0;
    endcase
  end

  assign is_dq_o = (type_i == T_DQWORD);
  assign is_xs_o = (type_i == T_XSTATE);
endmodule

// File: rtl/align_chk_classify.sv
module align_chk_classify
  import align_chk_pkg::*;
#(
  parameter bit XSAVE_GP = 1'b0
) (
  input  logic [LOW_W-1:0] addr_low_i,
  input  logic [LOW_W-1:0] mask_i,
  input  logic             is_dq_i,
  input  logic             is_xs_i,
  input  logic [1:0]       class_i,
  input  logic             implicit_priv_i,
  input  logic             ctl_mask_i,
  input  logic             task_flag_i,
  input  logic [1:0]       cpl_i,
  output verdict_e         verdict_o
);
  logic     misaligned;
  logic     checked_class;
  logic     ac_enabled;
  logic     gp_hit;
  logic     ac_hit;
  verdict_e xs_code;

  assign misaligned    = |(addr_low_i & mask_i);
  assign checked_class = (class_i == CLS_DATA) || (class_i == CLS_STACK);
  assign ac_enabled    = ctl_mask_i && task_flag_i && (cpl_i == 2'd3) && !implicit_priv_i;

  generate
    if (XSAVE_GP) begin : g_xs_gp
      assign xs_code = VERD_GP;
    end else begin : g_xs_ac
      assign xs_code = VERD_AC;
    end
  endgenerate

  assign gp_hit = checked_class && misaligned &&
                  (is_dq_i || (is_xs_i && ac_enabled && (xs_code == VERD_GP)));
  assign ac_hit = checked_class && misaligned && ac_enabled && !is_dq_i &&
                  !(is_xs_i && (xs_code == VERD_GP));

  // GP outranks AC
  always_comb begin
    if (gp_hit)      verdict_o = VERD_GP;
    else if (ac_hit) verdict_o = VERD_AC;
    else             verdict_o = VERD_PASS;
  end
endmodule

// File: rtl/align_chk_rsp_reg.sv
module align_chk_rsp_reg
  import align_chk_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  verdict_e          verdict_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [TYPE_W-1:0] type_i,
  input  logic              rsp_ready_i,
  output logic              rsp_valid_o,
  output verdict_e          rsp_verdict_o,
  output logic [ADDR_W-1:0] rsp_addr_o,
  output logic [TYPE_W-1:0] rsp_type_o,
  output logic              fault_pulse_o
);
  logic fire;

  assign req_ready_o = !rsp_valid_o || rsp_ready_i;
  assign fire        = req_valid_i && req_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o   <= 1'b0;
      rsp_verdict_o <= VERD_PASS;
      rsp_addr_o    <= '0;
      rsp_type_o    <= '0;
      fault_pulse_o <= 1'b0;
    end else begin
      fault_pulse_o <= fire && (verdict_i != VERD_PASS);
      if (fire) begin
        rsp_valid_o   <= 1'b1;
        rsp_verdict_o <= verdict_i;
        rsp_addr_o    <= addr_i;
        rsp_type_o    <= type_i;
      end else if (rsp_ready_i) begin
        rsp_valid_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/align_chk.sv
module align_chk
  import align_chk_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter bit XSAVE_GP = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [4:0]        req_type_i,
  input  logic              req_opsize32_i,
  input  logic [1:0]        req_class_i,
  input  logic              req_implicit_priv_i,
  input  logic              ctl_align_mask_i,
  input  logic              task_align_flag_i,
  input  logic [1:0]        cpl_i,
  output logic              rsp_valid_o,
  input  logic              rsp_ready_i,
  output logic [1:0]        rsp_verdict_o,
  output logic [ADDR_W-1:0] rsp_addr_o,
  output logic [4:0]        rsp_type_o,
  output logic              fault_pulse_o
);
  logic [LOW_W-1:0] mask;
  logic             is_dq;
  logic             is_xs;
  verdict_e         verdict;
  verdict_e         rsp_verdict;

  align_chk_decode u_decode (
    .type_i     (req_type_i),
    .opsize32_i (req_opsize32_i),
    .mask_o     (mask),
    .is_dq_o    (is_dq),
    .is_xs_o    (is_xs)
  );

  align_chk_classify #(.XSAVE_GP(XSAVE_GP)) u_classify (
    .addr_low_i      (req_addr_i[LOW_W-1:0]),
    .mask_i          (mask),
    .is_dq_i         (is_dq),
    .is_xs_i         (is_xs),
    .class_i         (req_class_i),
    .implicit_priv_i (req_implicit_priv_i),
    .ctl_mask_i      (ctl_align_mask_i),
    .task_flag_i     (task_align_flag_i),
    .cpl_i           (cpl_i),
    .verdict_o       (verdict)
  );

  align_chk_rsp_reg #(.ADDR_W(ADDR_W)) u_rsp (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .req_valid_i   (req_valid_i),
    .req_ready_o   (req_ready_o),
    .verdict_i     (verdict),
    .addr_i        (req_addr_i),
    .type_i        (req_type_i),
    .rsp_ready_i   (rsp_ready_i),
    .rsp_valid_o   (rsp_valid_o),
    .rsp_verdict_o (rsp_verdict),
    .rsp_addr_o    (rsp_addr_o),
    .rsp_type_o    (rsp_type_o),
    .fault_pulse_o (fault_pulse_o)
  );

  assign rsp_verdict_o = rsp_verdict;
endmodule

// File: rtl/align_chk_sva.sv
module align_chk_sva #(
  parameter int ADDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic [ADDR_W-1:0] req_addr_i,
  input logic [4:0]        req_type_i,
  input logic [1:0]        req_class_i,
  input logic              ctl_align_mask_i,
  input logic              task_align_flag_i,
  input logic [1:0]        cpl_i,
  input logic              rsp_valid_o,
  input logic              rsp_ready_i,
  input logic [1:0]        rsp_verdict_o,
  input logic [ADDR_W-1:0] rsp_addr_o,
  input logic [4:0]        rsp_type_o,
  input logic              fault_pulse_o
);
  logic fire;
  assign fire = req_valid_i && req_ready_o;

  // R12
  hold_until_taken_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rsp_ready_i |=> rsp_valid_o && $stable(rsp_verdict_o) &&
    $stable(rsp_addr_o) && $stable(rsp_type_o));

  // R13
  pulse_with_fault_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_pulse_o |-> rsp_valid_o && (rsp_verdict_o != 2'd0));

  // R3
  unchecked_class_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire && req_class_i[1] |=> rsp_verdict_o == 2'd0);

  // R2
  ac_needs_enables_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire && !(ctl_align_mask_i && task_align_flag_i && (cpl_i == 2'd3)) &&
    (req_type_i != 5'd4) |=> rsp_verdict_o != 2'd1);

  // R8
  dq_misalign_gp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire && !req_class_i[1] && (req_type_i == 5'd4) && (req_addr_i[3:0] != 4'd0)
    |=> rsp_verdict_o == 2'd2);

  // R11
  byte_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire && (req_type_i == 5'd0) |=> rsp_verdict_o == 2'd0);

  // R14
  addr_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire |=> (rsp_addr_o == $past(req_addr_i)) && (rsp_type_o == $past(req_type_i)));
endmodule

bind align_chk align_chk_sva #(.ADDR_W(ADDR_W)) u_sva (
  .clk_i             (clk_i),
  .rst_ni            (rst_ni),
  .req_valid_i       (req_valid_i),
  .req_ready_o       (req_ready_o),
  .req_addr_i        (req_addr_i),
  .req_type_i        (req_type_i),
  .req_class_i       (req_class_i),
  .ctl_align_mask_i  (ctl_align_mask_i),
  .task_align_flag_i (task_align_flag_i),
  .cpl_i             (cpl_i),
  .rsp_valid_o       (rsp_valid_o),
  .rsp_ready_i       (rsp_ready_i),
  .rsp_verdict_o     (rsp_verdict_o),
  .rsp_addr_o        (rsp_addr_o),
  .rsp_type_o        (rsp_type_o),
  .fault_pulse_o     (fault_pulse_o)
);

// File: tb/align_chk_tb_top.sv
module align_chk_tb_top;
  localparam int ADDR_W = 32;
  localparam bit XS_GP  = 1'b0;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [4:0]        req_type = '0;
  logic              req_os32 = 1'b0;
  logic [1:0]        req_cls = '0;
  logic              req_impl = 1'b0;
  logic              ctl_mask = 1'b0;
  logic              task_flag = 1'b0;
  logic [1:0]        cpl = '0;
  logic              rsp_valid;
  logic              rsp_ready = 1'b0;
  logic [1:0]        rsp_verdict;
  logic [ADDR_W-1:0] rsp_addr;
  logic [4:0]        rsp_type;
  logic              fault_pulse;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  // model state
  bit          m_valid = 0;
  int          m_verdict = 0;
  logic [31:0] m_addr = '0;
  int          m_type = 0;
  bit          m_pulse = 0;
  string       m_tag = "R1";

  always #4 clk = ~clk;

  align_chk #(.ADDR_W(ADDR_W), .XSAVE_GP(XS_GP)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_addr_i(req_addr), .req_type_i(req_type), .req_opsize32_i(req_os32),
    .req_class_i(req_cls), .req_implicit_priv_i(req_impl),
    .ctl_align_mask_i(ctl_mask), .task_align_flag_i(task_flag), .cpl_i(cpl),
    .rsp_valid_o(rsp_valid), .rsp_ready_i(rsp_ready), .rsp_verdict_o(rsp_verdict),
    .rsp_addr_o(rsp_addr), .rsp_type_o(rsp_type), .fault_pulse_o(fault_pulse)
  );

  task automatic check(string tag, longint act, longint exp, string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int ref_verdict(int addr, int typ, bit os32, int cls, bit impl,
                                     bit crm, bit tf, int pl, output string tag);
    int  need;
    bit  mis;
    bit  en;
    case (typ)
      1, 5, 6:           need = 2;
      2, 7, 8, 9, 12:    need = 4;
      3, 10, 11:         need = 8;
      13, 14, 15:        need = os32 ? 4 : 2;
      4, 16:             need = 16;
      default:           need = 1;
    endcase
    mis = (addr % need) != 0;
    if (cls >= 2) begin tag = "R3"; return 0; end
    if (typ == 4) begin tag = "R8"; return mis ? 2 : 0; end
    en = crm && tf && (pl == 3) && !impl;
    if (!en) begin tag = impl ? "R4" : "R2"; return 0; end
    if (typ == 16) begin tag = "R10"; return mis ? (XS_GP ? 2 : 1) : 0; end
    if (need == 1) begin tag = "R11"; return 0; end
    if (typ >= 13) tag = "R9";
    else if (need == 2) tag = "R5";
    else if (need == 4) tag = "R6";
    else tag = "R7";
    return mis ? 1 : 0;
  endfunction

  task automatic compare_outputs();
    check("R1/R12", rsp_valid, m_valid, "rsp_valid");
    check("R13", fault_pulse, m_pulse, "fault_pulse");
    if (m_valid) begin
      check(m_tag, rsp_verdict, m_verdict, "verdict");
      check("R14", rsp_addr, m_addr, "rsp_addr");
      check("R14", rsp_type, m_type, "rsp_type");
    end
  endtask

  task automatic cycle(bit v, int addr, int typ, bit os32, int cls, bit impl,
                       bit crm, bit tf, int pl, bit rr);
    bit    fire;
    int    vd;
    string tg;
    @(negedge clk);
    compare_outputs();
    req_valid = v; req_addr = addr; req_type = typ[4:0]; req_os32 = os32;
    req_cls = cls[1:0]; req_impl = impl; ctl_mask = crm; task_flag = tf;
    cpl = pl[1:0]; rsp_ready = rr;
    #1;
    check("R12", req_ready, !m_valid || rr, "req_ready");
    fire = v && (!m_valid || rr);
    vd = ref_verdict(addr, typ, os32, cls, impl, crm, tf, pl, tg);
    m_pulse = fire && (vd != 0);
    if (fire) begin
      m_valid = 1; m_verdict = vd; m_addr = addr; m_type = typ; m_tag = tg;
    end else if (rr) m_valid = 0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  %0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 8);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    #20;
    check("R1", rsp_valid, 0, "reset rsp_valid");
    check("R1", fault_pulse, 0, "reset fault_pulse");
    @(negedge clk); rst_n = 1'b1;
    // R5 R6 R7 R9 R10 R11: sweep types and offsets, checking enabled
    for (int os = 0; os < 2; os++)
      for (int t = 0; t < 21; t++)
        for (int a = 0; a < 18; a++)
          cycle(1, 32'h1000 + a, t, os[0], a % 2, 0, 1, 1, 3, 1);
    // R2: each enable missing
    for (int k = 0; k < 3; k++)
      for (int t = 0; t < 21; t++)
        for (int a = 0; a < 17; a += 3)
          cycle(1, a, t, 1, 0, 0, k != 0, k != 1, (k == 2) ? 0 : 3, 1);
    // R3 R4: unchecked classes and implicit privilege
    for (int t = 0; t < 21; t++)
      for (int a = 0; a < 16; a++) begin
        cycle(1, a, t, 1, 2 + (a % 2), 0, 1, 1, 3, 1);
        cycle(1, a, t, 1, a % 2, 1, 1, 1, 3, 1);
      end
    // R12 R13: backpressure hold
    cycle(1, 32'h33, 1, 0, 0, 0, 1, 1, 3, 0);
    cycle(1, 32'h40, 1, 0, 0, 0, 1, 1, 3, 0);
    cycle(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    cycle(0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    // random traffic
    for (int i = 0; i < 4000; i++) begin
      int a;
      a = $urandom;
      if ($urandom_range(1, 0) == 1) a = a & ~32'hF;
      else a = a & ~32'hF | $urandom_range(15, 0);
      cycle($urandom_range(3, 0) != 0, a, $urandom_range(31, 0), $urandom_range(1, 0),
            $urandom_range(3, 0), $urandom_range(7, 0) == 0, $urandom_range(3, 0) != 0,
            $urandom_range(3, 0) != 0, $urandom_range(3, 0), $urandom_range(2, 0) != 0);
    end
    cycle(0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    @(negedge clk);
    compare_outputs();
    finish_run();
  end
endmodule